// File: doc/BRIEF.md
# Tiled Systolic Matrix Multiplier

This block multiplies two fixed-point matrices, C = A×B, on a square grid of P×P multiply-accumulate cells. Operands larger than the grid are handled by cutting the product into P×P output tiles and computing one tile per pass. During a pass, each beat of the operand stream brings P elements of one column of A, one per tile row, and P elements of one row of B, one per tile column. After the shared dimension has been walked through, every cell holds one element of the tile. Passes run back to back, with no bubble between tiles, so the grid's skew is paid once per product and not once per tile.

The caller gives the three dimensions and a routing mode, pulses `start`, then streams operand beats in pass order. A mode input chooses how the two operand lanes reach the grid edges. In forward and backward products the X lanes feed the row edge. In weight-gradient products, where the left operand is a transposed activation matrix supplied on the Y lanes, the two lanes swap edges. The external memory is banked so that each beat's P values come from P separate banks. Results leave as P-wide tile rows on a valid/ready stream. The operand stream also uses valid/ready. When an operand beat is missing, the whole grid freezes. A result tile that cannot be handed off because the output buffer is still full stops operand intake until the buffer drains. `start`, `busy` and `done` are plain level and pulse signals.

Top module: `sa_tiled_mm`

## Requirements
- R1: After reset, `busy`, `done`, `res_valid` and `opnd_ready` are all low.
- R2: Each result beat is one row of a P×P tile of A×B. Lane j of `res_data` holds column j of the tile, as an AW-bit two's-complement sum of products of signed DW-bit operands. Correct results require dim_k ≥ 2P−1.
- R3: Tiles leave in pass order: row-block outer, column-block inner. Within a tile, rows leave from top to bottom.
- R4: Operand lanes whose row lies at or past dim_m, or whose column lies at or past dim_n, are replaced by zero whatever their value. The padded rows and columns of an edge tile read as zero.
- R5: Mode encodings: 0 forward and 1 backward, both with X lanes on the row edge and Y lanes on the column edge. 2 is weight-gradient, where Y lanes drive the row edge and X lanes drive the column edge. 3 acts as forward.
- R6: With no stall, `done` is high for exactly one cycle, ceil(dim_m/P)·ceil(dim_n/P)·dim_k + P − 1 cycles after the cycle in which `start` was high.
- R7: An operand beat moves only on `opnd_valid` and `opnd_ready` together. A cycle with no valid beat freezes the grid and leaves every result unchanged.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` hold their values.
- R9: `start` has no effect while `busy` is high. `opnd_ready` is never high while idle. `busy` falls once the last tile has been captured.
- R10: Exactly ceil(dim_m/P)·ceil(dim_n/P)·dim_k operand beats are accepted per product. Beats offered after that are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a product; sampled while idle |
| mode | input | 2 | Operand routing: 0 forward, 1 backward, 2 gradient |
| dim_m | input | DIMW | Rows of the result |
| dim_k | input | DIMW | Shared (accumulation) dimension |
| dim_n | input | DIMW | Columns of the result |
| busy | output | 1 | Product in progress |
| done | output | 1 | One-cycle pulse at the closed-form cycle count |
| opnd_valid | input | 1 | Operand beat present |
| opnd_ready | output | 1 | Operand beat accepted this cycle if valid |
| opnd_x | input | P×DW | X operand lanes, lane i at bits i·DW |
| opnd_y | input | P×DW | Y operand lanes, lane i at bits i·DW |
| res_valid | output | 1 | Result row present |
| res_ready | input | 1 | Sink takes the result row |
| res_data | output | P×AW | One tile row, lane j at bits j·AW |

## Verification
Assertions check the following on every cycle: a result row held under back-pressure stays put; `done` lasts a single cycle and only while busy; operand intake is closed when idle; and a missing operand beat freezes the skew lines, the grid edges and all accumulated results. Only the directed scenarios can show the arithmetic itself: the tile order, the zeroing of lanes past a ragged matrix edge, the swapped routing in gradient mode, the exact `done` cycle, and that a `start` pulse in mid-run leaves results untouched.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic [1:0] {
    OPM_FWD  = 2'd0,
    OPM_BWD  = 2'd1,
    OPM_GRAD = 2'd2,
    OPM_RSV  = 2'd3
  } opmode_e;

  // control bundle carried beside A data: {valid, first, last}
  localparam int CTLW = 3;
  localparam int CTL_V = 2;
  localparam int CTL_F = 1;
  localparam int CTL_L = 0;
endpackage

// File: rtl/sa_edge_skew.sv
module sa_edge_skew #(
  parameter int P = 4,
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [P-1:0][W-1:0] din,
  output logic [P-1:0][W-1:0] dout
);
  // lane i is delayed by i enabled cycles
  for (genvar i = 0; i < P; i++) begin : g_lane
    if (i == 0) begin : g_direct
      assign dout[i] = din[i];
    end else begin : g_delay
      logic [W-1:0] sr [i];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < i; s++) sr[s] <= '0;
        end else if (en_i) begin
          sr[0] <= din[i];
          for (int s = 1; s < i; s++) sr[s] <= sr[s-1];
        end
      end
      assign dout[i] = sr[i-1];
    end
  end
endmodule

// File: rtl/sa_pe.sv
module sa_pe
  import sa_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [DW-1:0]   a_i,
  input  logic [CTLW-1:0] ctl_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   a_o,
  output logic [CTLW-1:0] ctl_o,
  output logic [DW-1:0]   b_o,
  output logic [AW-1:0]   res_o
);
  logic signed [2*DW-1:0] prod;
  logic [AW-1:0] prod_x, acc, sum;

  assign prod   = $signed(a_i) * $signed(b_i);
  assign prod_x = {{(AW-2*DW){prod[2*DW-1]}}, prod};
  assign sum    = ctl_i[CTL_F] ? prod_x : acc + prod_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_o   <= '0;
      ctl_o <= '0;
      b_o   <= '0;
      acc   <= '0;
      res_o <= '0;
    end else if (en_i) begin
      a_o   <= a_i;
      ctl_o <= ctl_i;
      b_o   <= b_i;
      if (ctl_i[CTL_V]) begin
        acc <= sum;
        if (ctl_i[CTL_L]) res_o <= sum;
      end
    end
  end
endmodule

// File: rtl/sa_tile_seq.sv
module sa_tile_seq #(
  parameter int P    = 4,
  parameter int DIMW = 8,
  parameter int SW   = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [DIMW-1:0] n1_i,
  input  logic [DIMW-1:0] n2_i,
  input  logic [DIMW-1:0] n3_i,
  input  logic            adv_i,
  input  logic            snap_i,
  output logic            busy_o,
  output logic            feed_o,
  output logic            first_o,
  output logic            last_o,
  output logic [P-1:0]    rmask_o,
  output logic [P-1:0]    cmask_o,
  output logic            done_o
);
  localparam int IW = DIMW + 1;

  logic [DIMW-1:0] n1q, n2q, n3q, tcc, kcnt, rb, cb;
  logic [SW-1:0]   step, tbeats, ntiles, snaps;
  logic [IW-1:0]   trc_w, tcc_w;

  assign trc_w = (IW'(n1_i) + IW'(P - 1)) / IW'(P);
  assign tcc_w = (IW'(n3_i) + IW'(P - 1)) / IW'(P);

  assign feed_o  = busy_o && (step < tbeats);
  assign first_o = (kcnt == '0);
  assign last_o  = (kcnt == n2q - 1'b1);

  always_comb begin
    for (int i = 0; i < P; i++) begin
      rmask_o[i] = feed_o && ((SW'(rb) * SW'(P) + SW'(i)) < SW'(n1q));
      cmask_o[i] = feed_o && ((SW'(cb) * SW'(P) + SW'(i)) < SW'(n3q));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      n1q <= '0; n2q <= '0; n3q <= '0; tcc <= '0;
      kcnt <= '0; rb <= '0; cb <= '0;
      step <= '0; tbeats <= '0; ntiles <= '0; snaps <= '0;
    end else begin
      done_o <= busy_o && adv_i && (step == tbeats + SW'(P) - SW'(3));
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          n1q <= n1_i; n2q <= n2_i; n3q <= n3_i;
          tcc <= DIMW'(tcc_w);
          kcnt <= '0; rb <= '0; cb <= '0;
          step <= '0; snaps <= '0;
          ntiles <= SW'(trc_w) * SW'(tcc_w);
          tbeats <= SW'(trc_w) * SW'(tcc_w) * SW'(n2_i);
        end
      end else begin
        if (adv_i) begin
          step <= step + 1'b1;
          if (feed_o) begin
            if (last_o) begin
              kcnt <= '0;
              if (cb == tcc - 1'b1) begin
                cb <= '0;
                rb <= rb + 1'b1;
              end else begin
                cb <= cb + 1'b1;
              end
            end else begin
              kcnt <= kcnt + 1'b1;
            end
          end
        end
        if (snap_i) begin
          snaps <= snaps + 1'b1;
          if (snaps == ntiles - 1'b1) busy_o <= 1'b0;
        end
      end
    end
  end

  assert_done_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/sa_tiled_mm.sv
module sa_tiled_mm
  import sa_pkg::*;
#(
  parameter int P    = 4,
  parameter int DW   = 8,
  parameter int AW   = 24,
  parameter int DIMW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic [DIMW-1:0]      dim_m,
  input  logic [DIMW-1:0]      dim_k,
  input  logic [DIMW-1:0]      dim_n,
  output logic                 busy,
  output logic                 done,
  input  logic                 opnd_valid,
  output logic                 opnd_ready,
  input  logic [P-1:0][DW-1:0] opnd_x,
  input  logic [P-1:0][DW-1:0] opnd_y,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [P-1:0][AW-1:0] res_data
);
  localparam int SW  = 3 * DIMW;
  localparam int RW  = DW + CTLW;
  localparam int RIW = (P > 1) ? $clog2(P) : 1;

  logic feed, kfirst, klast, adv, adv_q, hold, snap, pend, rv_evt, obuf_full;
  logic [P-1:0] rmask, cmask;
  opmode_e mode_q;
  logic [P-1:0][DW-1:0] row_src, col_src, col_in, col_sk;
  logic [P-1:0][RW-1:0] row_in, row_sk, row_exit;
  logic [P-1:0][DW-1:0] col_exit;
  logic [P-1:0][P-1:0][AW-1:0] pres, obuf;
  logic [RIW-1:0] orow;

  logic [DW-1:0]   ah [P][P+1];
  logic [CTLW-1:0] ch [P][P+1];
  logic [DW-1:0]   bv [P+1][P];

  sa_tile_seq #(.P(P), .DIMW(DIMW), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .n1_i(dim_m), .n2_i(dim_k), .n3_i(dim_n),
    .adv_i(adv), .snap_i(snap), .busy_o(busy), .feed_o(feed),
    .first_o(kfirst), .last_o(klast), .rmask_o(rmask), .cmask_o(cmask),
    .done_o(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= OPM_FWD;
    else if (start && !busy) mode_q <= opmode_e'(mode);
  end

  // edge routing: gradient swaps which operand lane feeds the rows
  always_comb begin
    row_src = (mode_q == OPM_GRAD) ? opnd_y : opnd_x;
    col_src = (mode_q == OPM_GRAD) ? opnd_x : opnd_y;
    for (int i = 0; i < P; i++) begin
      row_in[i] = {feed, kfirst, klast, (rmask[i] ? row_src[i] : {DW{1'b0}})};
      col_in[i] = cmask[i] ? col_src[i] : {DW{1'b0}};
    end
  end

  sa_edge_skew #(.P(P), .W(RW)) u_row_skew (
    .clk(clk), .rst_n(rst_n), .en_i(adv), .din(row_in), .dout(row_sk));
  sa_edge_skew #(.P(P), .W(DW)) u_col_skew (
    .clk(clk), .rst_n(rst_n), .en_i(adv), .din(col_in), .dout(col_sk));

  for (genvar i = 0; i < P; i++) begin : g_edge
    assign ah[i][0]    = row_sk[i][DW-1:0];
    assign ch[i][0]    = row_sk[i][RW-1:DW];
    assign bv[0][i]    = col_sk[i];
    assign row_exit[i] = {ch[i][P], ah[i][P]};
    assign col_exit[i] = bv[P][i];
  end

  for (genvar i = 0; i < P; i++) begin : g_row
    for (genvar j = 0; j < P; j++) begin : g_col
      sa_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk(clk), .rst_n(rst_n), .en_i(adv),
        .a_i(ah[i][j]), .ctl_i(ch[i][j]), .b_i(bv[i][j]),
        .a_o(ah[i][j+1]), .ctl_o(ch[i][j+1]), .b_o(bv[i+1][j]),
        .res_o(pres[i][j])
      );
    end
  end

  // the far corner's last flag leaving the grid marks a finished tile
  assign rv_evt = busy && adv_q && ch[P-1][P][CTL_V] && ch[P-1][P][CTL_L];
  assign hold   = (rv_evt || pend) && obuf_full;
  assign snap   = (rv_evt || pend) && !obuf_full;
  assign adv    = busy && !hold && (feed ? opnd_valid : 1'b1);
  assign opnd_ready = busy && feed && !hold;

  assign res_valid = obuf_full;
  assign res_data  = obuf[orow];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adv_q     <= 1'b0;
      pend      <= 1'b0;
      obuf_full <= 1'b0;
      obuf      <= '0;
      orow      <= '0;
    end else begin
      adv_q <= adv;
      pend  <= hold;
      if (snap) begin
        obuf      <= pres;
        obuf_full <= 1'b1;
        orow      <= '0;
      end else if (obuf_full && res_ready) begin
        if (orow == RIW'(P - 1)) begin
          obuf_full <= 1'b0;
          orow      <= '0;
        end else begin
          orow <= orow + 1'b1;
        end
      end
    end
  end

  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
  assert_idle_no_intake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !opnd_ready);
  assert_stall_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_ready && !opnd_valid) |=> ($stable(row_sk) && $stable(col_sk) &&
      $stable(row_exit) && $stable(col_exit) && $stable(pres)));
  assert_no_snap_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && pend) |=> res_valid);
endmodule

// File: tb/sa_tiled_mm_tb_top.sv
`timescale 1ns/1ps
module sa_tiled_mm_tb_top;
  localparam int P = 4;
  localparam int DW = 8;
  localparam int AW = 24;
  localparam int DIMW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [DIMW-1:0] dim_m = '0, dim_k = '0, dim_n = '0;
  logic busy, done, opnd_ready, res_valid;
  logic opnd_valid = 1'b0;
  logic res_ready = 1'b0;
  logic [P-1:0][DW-1:0] opnd_x = '0, opnd_y = '0;
  logic [P-1:0][AW-1:0] res_data;

  int tests = 0;
  int fails = 0;
  int wd = 0;

  always #2.5 clk = ~clk;

  sa_tiled_mm #(.P(P), .DW(DW), .AW(AW), .DIMW(DIMW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .dim_m(dim_m), .dim_k(dim_k), .dim_n(dim_n),
    .busy(busy), .done(done),
    .opnd_valid(opnd_valid), .opnd_ready(opnd_ready),
    .opnd_x(opnd_x), .opnd_y(opnd_y),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data));

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog R6: actual=%0d cycles expected<150000", wd);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int aval(int r, int k);
    return ((r * 5 + k * 3 + 1) % 13) - 6;
  endfunction
  function automatic int bval(int k, int c);
    return ((k * 7 + c * 2 + 3) % 11) - 5;
  endfunction

  // expected tile element, padded entries are zero (R4)
  function automatic longint cexp(int r, int c, int n1, int n2, int n3);
    longint s = 0;
    if (r >= n1 || c >= n3) return 0;
    for (int k = 0; k < n2; k++) s += longint'(aval(r, k) * bval(k, c));
    return s;
  endfunction

  task automatic run_case(input int md, input int n1, input int n2, input int n3,
                          input bit gaps, input bit bp, input bit poke,
                          input string req);
    int trc = (n1 + P - 1) / P;
    int tcc = (n3 + P - 1) / P;
    int tb = trc * tcc * n2;
    int nrows = trc * tcc * P;
    int got_rows = 0;
    int extra = 0;
    int dcyc = 0;
    bit dseen = 0;
    @(negedge clk);
    mode = 2'(md); dim_m = DIMW'(n1); dim_k = DIMW'(n2); dim_n = DIMW'(n3);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    fork
      begin : feeder
        int s = 0;
        int cyc = 0;
        while (s < tb) begin
          int t = s / n2;
          int k = s % n2;
          int rb = t / tcc;
          int cb = t % tcc;
          logic [P-1:0][DW-1:0] rowv, colv;
          for (int i = 0; i < P; i++) begin
            rowv[i] = (rb * P + i < n1) ? DW'(aval(rb * P + i, k)) : DW'(77);
            colv[i] = (cb * P + i < n3) ? DW'(bval(k, cb * P + i)) : DW'(-55);
          end
          if (md == 2) begin opnd_y = rowv; opnd_x = colv; end
          else begin opnd_x = rowv; opnd_y = colv; end
          opnd_valid = !(gaps && (cyc % 4 == 1));
          if (opnd_valid && opnd_ready) s++;
          cyc++;
          @(negedge clk);
        end
        // R10: further beats must not be taken
        for (int e = 0; e < 6; e++) begin
          opnd_valid = 1'b1;
          opnd_x = '1;
          if (opnd_ready) extra++;
          @(negedge clk);
        end
        opnd_valid = 1'b0;
        chk(extra == 0, "R10", "beats taken after the product's count", extra, 0);
      end
      begin : collector
        int cyc = 0;
        while (got_rows < nrows && cyc < 20000) begin
          res_ready = bp ? (cyc % 3 != 0) : 1'b1;
          if (res_valid && res_ready) begin
            int t = got_rows / P;
            int i = got_rows % P;
            int r = (t / tcc) * P + i;
            int c0 = (t % tcc) * P;
            bit ok = 1;
            longint a0 = 0, e0 = 0;
            for (int j = 0; j < P; j++) begin
              longint act = longint'($signed(res_data[j]));
              longint ex = cexp(r, c0 + j, n1, n2, n3);
              if (act != ex && ok) begin ok = 0; a0 = act; e0 = ex; end
            end
            // R2 value, R3 order, R4 padding, R5 routing via req
            chk(ok, req, $sformatf("tile row %0d (r=%0d c0=%0d)", got_rows, r, c0), a0, e0);
            got_rows++;
          end
          cyc++;
          @(negedge clk);
        end
        res_ready = 1'b0;
        chk(got_rows == nrows, "R3", "result rows delivered", got_rows, nrows);
      end
      begin : done_watch
        int c = 1;
        while (!done && c < 20000) begin @(negedge clk); c++; end
        dcyc = c;
        dseen = done;
        @(negedge clk);
        chk(!done, "R6", "done lasts one cycle", done, 0);
      end
      begin : poker
        if (poke) begin
          repeat (8) @(negedge clk);
          dim_m = 8'd3; dim_k = 8'd9; dim_n = 8'd2; mode = 2'd2;
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    if (!gaps && !bp)
      chk(dseen && dcyc == tb + P - 1, "R6", "done cycle after start", dcyc, tb + P - 1);
    for (int w = 0; w < 40 && busy; w++) @(negedge clk);
    chk(!busy, "R9", "busy cleared after last tile", busy, 0);
  endtask

  task automatic t_reset;
    chk(!busy, "R1", "busy after reset", busy, 0);
    chk(!done, "R1", "done after reset", done, 0);
    chk(!res_valid, "R1", "res_valid after reset", res_valid, 0);
    chk(!opnd_ready, "R1", "opnd_ready after reset", opnd_ready, 0);
  endtask

  task automatic t_forward_square;
    run_case(0, 8, 8, 8, 0, 0, 0, "R2");
  endtask

  task automatic t_ragged_edges;
    run_case(0, 6, 7, 5, 0, 0, 0, "R4");
  endtask

  task automatic t_gradient_swap;
    run_case(2, 5, 9, 8, 0, 0, 0, "R5");
  endtask

  task automatic t_backward_route;
    run_case(1, 4, 7, 4, 0, 0, 0, "R5");
  endtask

  task automatic t_reserved_mode;
    run_case(3, 4, 8, 7, 0, 0, 0, "R5");
  endtask

  task automatic t_stalls_and_poke;
    // R7 gaps, R8 output back-pressure, R9 start while busy
    run_case(0, 9, 8, 6, 1, 1, 1, "R7");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward_square();
    t_ragged_edges();
    t_gradient_swap();
    t_backward_route();
    t_reserved_mode();
    t_stalls_and_poke();
    t_forward_square();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule